// File: doc/BRIEF.md
# Speed and Rotor-Lock Feedback Pin Driver

This block drives the pull-down enable of a single open-drain feedback pin that a fan controller reads. When the pin is released, an external pull-up makes it read high. When the pull-down is enabled, it reads low. The pin works in one of two roles. As a speed pulse, it toggles at a chosen multiple of the Hall sensor rate. As a ready/lock flag, it gives a static level for each motor state.

The speed rate is synthesized from Hall edges. The block measures the interval between Hall edges with a counter, and a mid-interval toggle gives the doubled rate. A divide-by-three edge phase, combined with that mid-interval toggle, gives the two-thirds rate. A new rate code takes effect at the next Hall edge, so a change never leaves a runt pulse.

The levels for locked rotor, device fault and idle come from the mode, polarity and fault-select bits. The idle level is always the opposite of the lock indication level.

Top module: `tach_flag_driver`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `pin_pd_o` is 0 (pin released).
- R2: The rate code `cfg_rate_i` is encoded as follows: 00 = half rate, 01 = equal rate, 10 = two-thirds rate, 11 = double rate. In speed mode (`cfg_ready_i`=0) at equal rate, the output toggles once per edge of the selected Hall source. The change appears on `pin_pd_o` two clock edges after the Hall input change is sampled.
- R3: At half rate, the output toggles on every second Hall edge.
- R4: At double rate, the output toggles on every Hall edge. It toggles once more midway to the next edge, with the midpoint taken from the previously measured edge interval.
- R5: At two-thirds rate, the output toggles twice in every three Hall edges, so the output period is one and a half Hall periods.
- R6: `cfg_src_raw_i`=1 makes the speed output follow `hall_raw_i`. `cfg_src_raw_i`=0 makes it follow `hall_ofs_i`, and edges on the unselected input have no effect.
- R7: When the raw source is selected with code 10, the block runs at equal rate.
- R8: A rate-code change takes effect at the next selected Hall edge. Toggles already scheduled by the current edge still occur.
- R9: Priority is lock, then fault, then idle, then active. A locked rotor (`st_lock_i`=1) gives pin low when `cfg_invert_i`=0 and pin released when `cfg_invert_i`=1, in either mode, one clock edge after it is sampled.
- R10: With `cfg_fault_sel_i`=0, a device fault (`st_fault_i`=1 without lock) holds the pin at its present level, even if the configuration changes. With `cfg_fault_sel_i`=1, a fault gives the lock level.
- R11: When idle (`st_idle_i`=1, or `st_active_i`=0), with no lock or fault, the pin sits at the level opposite the lock level.
- R12: In ready mode (`cfg_ready_i`=1), active running without lock, fault or idle gives the level opposite the lock level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hall_raw_i | input | 1 | Raw Hall sensor signal, already synchronous to clk |
| hall_ofs_i | input | 1 | Offset-corrected Hall signal, synchronous to clk |
| cfg_ready_i | input | 1 | 0 = speed pulse role, 1 = ready/lock flag role |
| cfg_invert_i | input | 1 | Polarity of the lock indication (1 = lock shown high) |
| cfg_fault_sel_i | input | 1 | 1 = fault shown like lock, 0 = fault holds the pin |
| cfg_src_raw_i | input | 1 | 1 = use raw Hall, 0 = use offset-corrected Hall |
| cfg_rate_i | input | 2 | Speed rate code (00 half, 01 equal, 10 two-thirds, 11 double) |
| st_active_i | input | 1 | Motor is actively driven |
| st_idle_i | input | 1 | Motor commanded to zero duty |
| st_lock_i | input | 1 | Locked rotor detected |
| st_fault_i | input | 1 | Device fault present |
| pin_pd_o | output | 1 | Pin pull-down enable (1 = pin low) |

## Verification
A status or configuration change sampled at one clock edge appears on `pin_pd_o` after that same edge, so the bench checks it one cycle after driving it. A Hall change passes through the speed register and then the output register, so it shows two edges later. The bench checks that the pin is unchanged after one edge and has toggled after two. Rate checks drive Hall edges twenty cycles apart. They count the pin transitions seen at every falling clock edge over a whole number of edge slots, after warm-up edges have set the measured interval. Every mid-interval toggle falls well inside its slot, so the counts are exact.

// File: rtl/tfd_pkg.sv
// Shared types for the feedback pin driver.
package tfd_pkg;
    // Speed rate codes; the encoding is visible at the top-level port.
    typedef enum logic [1:0] {
        RATE_HALF = 2'b00,
        RATE_ONE  = 2'b01,
        RATE_TWO3 = 2'b10,
        RATE_DBL  = 2'b11
    } rate_e;
endpackage

// File: rtl/tfd_edge_meter.sv
// Detects both edges of the selected Hall signal and measures the interval
// between consecutive edges in clock cycles. It raises a one-cycle mid strobe
// halfway through the current interval, based on the previous interval.
// Assumes src_i is synchronous to clk. The counter saturates on very slow
// rotation, and no mid strobe is given before a first interval of at least
// two cycles has been measured.
module tfd_edge_meter #(
    parameter int CNT_W = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic src_i,
    output logic edge_o,
    output logic mid_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] MIN_SPAN = CNT_W'(2);

    logic             prev_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] span_q;
    logic             armed_q;
    logic [CNT_W-1:0] mid_pt;

    assign edge_o = src_i ^ prev_q;
    assign mid_pt = (span_q >> 1) - CNT_W'(1);
    assign mid_o  = armed_q && !edge_o && (span_q >= MIN_SPAN) && (cnt_q == mid_pt);

    // Keep last sample of the source for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= src_i;
    end

    // Count cycles since the last edge, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (edge_o)         cnt_q <= '0;
        else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + CNT_W'(1);
    end

    // Capture the finished interval length at each edge.
    always_ff @(posedge clk) begin
        if (!rst_n)      span_q <= '0;
        else if (edge_o) span_q <= (cnt_q == CNT_MAX) ? CNT_MAX : cnt_q + CNT_W'(1);
    end

    // Allow one mid strobe per interval.
    always_ff @(posedge clk) begin
        if (!rst_n)      armed_q <= 1'b0;
        else if (edge_o) armed_q <= 1'b1;
        else if (mid_o)  armed_q <= 1'b0;
    end
endmodule

// File: rtl/tfd_rate_shaper.sv
// Produces the speed pulse level from Hall edges and mid strobes. The rate
// code is applied at an edge and then held, so a mid toggle scheduled by an
// edge still happens if the code changes afterwards. A phase counter gives the
// half and two-thirds rates; it restarts when the rate changes.
// Assumes edge_i and mid_i never coincide.
module tfd_rate_shaper
    import tfd_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  edge_i,
    input  logic  mid_i,
    input  rate_e rate_i,
    output logic  sp_o
);
    rate_e      rate_q;
    logic [1:0] ph_q;
    logic       want_q;
    logic       sp_q;

    logic [1:0] ph_use;
    logic [1:0] ph_nxt;
    logic       tog_edge;
    logic       want_nxt;

    // Decide the action taken at an edge for the requested rate.
    always_comb begin
        ph_use   = (rate_i == rate_q) ? ph_q : 2'd0;
        tog_edge = 1'b1;
        want_nxt = 1'b0;
        ph_nxt   = 2'd0;
        case (rate_i)
            RATE_HALF: begin
                tog_edge = !ph_use[0];
                ph_nxt   = {1'b0, ~ph_use[0]};
            end
            RATE_TWO3: begin
                tog_edge = (ph_use == 2'd0);
                want_nxt = (ph_use == 2'd1);
                ph_nxt   = (ph_use == 2'd2) ? 2'd0 : ph_use + 2'd1;
            end
            RATE_DBL: begin
                want_nxt = 1'b1;
            end
            default: begin
                tog_edge = 1'b1;
            end
        endcase
    end

    // Apply edge actions and scheduled mid toggles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rate_q <= RATE_ONE;
            ph_q   <= 2'd0;
            want_q <= 1'b0;
            sp_q   <= 1'b1;
        end else if (edge_i) begin
            rate_q <= rate_i;
            ph_q   <= ph_nxt;
            want_q <= want_nxt;
            sp_q   <= sp_q ^ tog_edge;
        end else if (mid_i && want_q) begin
            want_q <= 1'b0;
            sp_q   <= ~sp_q;
        end
    end

    assign sp_o = sp_q;
endmodule

// File: rtl/tfd_level_mux.sv
// Chooses the pin level from status and configuration, and registers the
// pull-down enable. Priority: lock, fault, idle, active. A fault with
// fault-select clear holds the registered level. Assumes status flags are
// synchronous to clk.
module tfd_level_mux (
    input  logic clk,
    input  logic rst_n,
    input  logic ready_i,
    input  logic invert_i,
    input  logic fault_sel_i,
    input  logic active_i,
    input  logic idle_i,
    input  logic lock_i,
    input  logic fault_i,
    input  logic sp_i,
    output logic pd_o
);
    logic pd_q;
    logic ind_lvl;
    logic lvl;

    assign ind_lvl = invert_i;

    // Pick the pin level (1 = released/high).
    always_comb begin
        if (lock_i)                   lvl = ind_lvl;
        else if (fault_i)             lvl = fault_sel_i ? ind_lvl : ~pd_q;
        else if (idle_i || !active_i) lvl = ~ind_lvl;
        else if (ready_i)             lvl = ~ind_lvl;
        else                          lvl = sp_i;
    end

    // Register the pull-down enable.
    always_ff @(posedge clk) begin
        if (!rst_n) pd_q <= 1'b0;
        else        pd_q <= ~lvl;
    end

    assign pd_o = pd_q;
endmodule

// File: rtl/tach_flag_driver.sv
// Top of the feedback pin driver. Selects the Hall source, replaces the
// unsupported raw two-thirds combination with equal rate, and chains the edge
// meter, rate shaper and level mux. Inputs are assumed synchronous to clk.
module tach_flag_driver
    import tfd_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hall_raw_i,
    input  logic       hall_ofs_i,
    input  logic       cfg_ready_i,
    input  logic       cfg_invert_i,
    input  logic       cfg_fault_sel_i,
    input  logic       cfg_src_raw_i,
    input  logic [1:0] cfg_rate_i,
    input  logic       st_active_i,
    input  logic       st_idle_i,
    input  logic       st_lock_i,
    input  logic       st_fault_i,
    output logic       pin_pd_o
);
    logic  hall_sel;
    logic  edge_s;
    logic  mid_s;
    logic  sp_s;
    rate_e rate_req;

    assign hall_sel = cfg_src_raw_i ? hall_raw_i : hall_ofs_i;

    // Raw source cannot run two-thirds; use equal rate instead.
    always_comb begin
        if (cfg_src_raw_i && (rate_e'(cfg_rate_i) == RATE_TWO3)) rate_req = RATE_ONE;
        else                                                     rate_req = rate_e'(cfg_rate_i);
    end

    tfd_edge_meter #(.CNT_W(CNT_W)) u_meter (
        .clk    (clk),
        .rst_n  (rst_n),
        .src_i  (hall_sel),
        .edge_o (edge_s),
        .mid_o  (mid_s)
    );

    tfd_rate_shaper u_shaper (
        .clk    (clk),
        .rst_n  (rst_n),
        .edge_i (edge_s),
        .mid_i  (mid_s),
        .rate_i (rate_req),
        .sp_o   (sp_s)
    );

    tfd_level_mux u_mux (
        .clk         (clk),
        .rst_n       (rst_n),
        .ready_i     (cfg_ready_i),
        .invert_i    (cfg_invert_i),
        .fault_sel_i (cfg_fault_sel_i),
        .active_i    (st_active_i),
        .idle_i      (st_idle_i),
        .lock_i      (st_lock_i),
        .fault_i     (st_fault_i),
        .sp_i        (sp_s),
        .pd_o        (pin_pd_o)
    );
endmodule

// File: rtl/tfd_checker.sv
// Property checks on the feedback pin driver's port behaviour.
module tfd_checker (
    input logic clk,
    input logic rst_n,
    input logic cfg_ready_i,
    input logic cfg_invert_i,
    input logic cfg_fault_sel_i,
    input logic st_active_i,
    input logic st_idle_i,
    input logic st_lock_i,
    input logic st_fault_i,
    input logic pin_pd_o
);
    // R1
    reset_release_chk: assert property (@(posedge clk) !rst_n |=> !pin_pd_o);

    // R9
    lock_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_lock_i && !cfg_invert_i) |=> pin_pd_o);

    // R9
    lock_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_lock_i && cfg_invert_i) |=> !pin_pd_o);

    // R10
    fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_fault_i && !st_lock_i && !cfg_fault_sel_i) |=> $stable(pin_pd_o));

    // R10
    fault_as_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_fault_i && !st_lock_i && cfg_fault_sel_i) |=> (pin_pd_o == !$past(cfg_invert_i)));

    // R11
    idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_lock_i && !st_fault_i && (st_idle_i || !st_active_i)) |=> (pin_pd_o == $past(cfg_invert_i)));

    // R12
    ready_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_ready_i && st_active_i && !st_idle_i && !st_lock_i && !st_fault_i)
        |=> (pin_pd_o == $past(cfg_invert_i)));
endmodule

bind tach_flag_driver tfd_checker u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .cfg_ready_i     (cfg_ready_i),
    .cfg_invert_i    (cfg_invert_i),
    .cfg_fault_sel_i (cfg_fault_sel_i),
    .st_active_i     (st_active_i),
    .st_idle_i       (st_idle_i),
    .st_lock_i       (st_lock_i),
    .st_fault_i      (st_fault_i),
    .pin_pd_o        (pin_pd_o)
);

// File: tb/sim_tach_flag_driver.sv
`timescale 1ns/1ps
module sim_tach_flag_driver;
    localparam int SLOT = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hall_raw = 1'b0, hall_ofs = 1'b0;
    logic       ready = 1'b0, invert = 1'b0, fsel = 1'b0, src_raw = 1'b0;
    logic [1:0] rate = 2'b01;
    logic       active = 1'b0, idle = 1'b0, lock = 1'b0, fault = 1'b0;
    logic       pd;
    int         n_chk = 0, n_fail = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    tach_flag_driver u0 (
        .clk(clk), .rst_n(rst_n), .hall_raw_i(hall_raw), .hall_ofs_i(hall_ofs),
        .cfg_ready_i(ready), .cfg_invert_i(invert), .cfg_fault_sel_i(fsel),
        .cfg_src_raw_i(src_raw), .cfg_rate_i(rate), .st_active_i(active),
        .st_idle_i(idle), .st_lock_i(lock), .st_fault_i(fault), .pin_pd_o(pd)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Drive n Hall edges one slot apart, counting pin transitions.
    task automatic run_edges(input int n, input bit on_raw, input bit on_ofs, output int tog);
        logic last;
        tog = 0;
        for (int e = 0; e < n; e++) begin
            @(negedge clk);
            if (on_raw) hall_raw = ~hall_raw;
            if (on_ofs) hall_ofs = ~hall_ofs;
            last = pd;
            for (int c = 0; c < SLOT; c++) begin
                @(negedge clk);
                if (pd != last) tog++;
                last = pd;
            end
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(pd == 1'b0, "R1 in reset", pd, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(pd == 1'b0, "R1 after reset", pd, 0);
    endtask

    task automatic t_latency();
        logic p;
        int t;
        active = 1'b1; rate = 2'b01; src_raw = 1'b0;
        run_edges(2, 1'b0, 1'b1, t);
        @(negedge clk);
        p = pd;
        hall_ofs = ~hall_ofs;
        @(negedge clk);
        chk(pd == p, "R2 one edge later", pd, p);
        @(negedge clk);
        chk(pd == !p, "R2 two edges later", pd, !p);
        repeat (SLOT) @(negedge clk);
    endtask

    task automatic t_rate(input logic [1:0] code, input bit raw, input int exp, input string req);
        int t;
        rate = code; src_raw = raw;
        run_edges(3, raw, !raw, t);
        run_edges(12, raw, !raw, t);
        chk(t == exp, req, t, exp);
    endtask

    task automatic t_source();
        int t;
        rate = 2'b01; src_raw = 1'b0;
        run_edges(12, 1'b1, 1'b0, t);
        chk(t == 0, "R6 unselected raw ignored", t, 0);
        src_raw = 1'b1;
        run_edges(2, 1'b1, 1'b0, t);
        run_edges(12, 1'b0, 1'b1, t);
        chk(t == 0, "R6 unselected ofs ignored", t, 0);
        run_edges(12, 1'b1, 1'b0, t);
        chk(t == 12, "R6 raw followed", t, 12);
        src_raw = 1'b0;
        run_edges(2, 1'b0, 1'b1, t);
    endtask

    task automatic t_change();
        int t;
        logic last;
        rate = 2'b11; src_raw = 1'b0;
        run_edges(3, 1'b0, 1'b1, t);
        @(negedge clk);
        hall_ofs = ~hall_ofs;
        repeat (3) @(negedge clk);
        rate = 2'b00;
        last = pd; t = 0;
        for (int c = 0; c < SLOT - 3; c++) begin
            @(negedge clk);
            if (pd != last) t++;
            last = pd;
        end
        chk(t == 1, "R8 scheduled mid toggle kept", t, 1);
        run_edges(12, 1'b0, 1'b1, t);
        chk(t == 6, "R8 new rate after edge", t, 6);
    endtask

    task automatic set_and_check(input logic exp_pd, input string req);
        @(negedge clk);
        @(negedge clk);
        chk(pd == exp_pd, req, pd, exp_pd);
    endtask

    task automatic t_levels();
        ready = 1'b0; invert = 1'b0; lock = 1'b1;
        set_and_check(1'b1, "R9 speed lock non-inverted low");
        invert = 1'b1;
        set_and_check(1'b0, "R9 speed lock inverted high");
        lock = 1'b0; ready = 1'b1; invert = 1'b0;
        set_and_check(1'b0, "R12 ready active non-inverted high");
        lock = 1'b1;
        set_and_check(1'b1, "R9 ready lock non-inverted low");
        lock = 1'b0; invert = 1'b1;
        set_and_check(1'b1, "R12 ready active inverted low");
        lock = 1'b1; fault = 1'b1;
        set_and_check(1'b0, "R9 lock outranks fault");
        lock = 1'b0; fault = 1'b0;
        set_and_check(1'b1, "R12 back to active");
        fault = 1'b1; fsel = 1'b0;
        set_and_check(1'b1, "R10 fault holds");
        invert = 1'b0; ready = 1'b0; idle = 1'b1;
        repeat (5) @(negedge clk);
        chk(pd == 1'b1, "R10 hold across config change", pd, 1);
        fsel = 1'b1; invert = 1'b1;
        set_and_check(1'b0, "R10 fault as lock inverted");
        invert = 1'b0;
        set_and_check(1'b1, "R10 fault as lock non-inverted");
        fault = 1'b0; fsel = 1'b0;
        set_and_check(1'b0, "R11 idle non-inverted high");
        invert = 1'b1;
        set_and_check(1'b1, "R11 idle inverted low");
        idle = 1'b0; active = 1'b0; invert = 1'b0;
        set_and_check(1'b0, "R11 not active shows idle level");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        t_latency();
        t_rate(2'b01, 1'b0, 12, "R2 equal rate count");
        t_rate(2'b00, 1'b0, 6, "R3 half rate count");
        t_rate(2'b11, 1'b0, 24, "R4 double rate count");
        t_rate(2'b10, 1'b0, 8, "R5 two-thirds rate count");
        t_rate(2'b10, 1'b1, 12, "R7 raw two-thirds falls back");
        t_source();
        t_change();
        t_levels();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule